// File: doc/BRIEF.md
# Conversion Trigger Interval Timer

This block paces a queued analog-to-digital sequencer. A free-running counter advances on a one-cycle prescaled-clock enable. Once the count spans the selected interval, the block sends a one-cycle trigger pulse to each of the two conversion queues that is in an active timer mode. Each queue has a control register that holds a 2-bit mode and a single-scan arm bit. A queue uses the timer in either of two modes: periodic mode, which re-triggers on every interval, or interval single-scan mode, which fires once and then disarms itself.

Most of the logic decides whether the counter may run. The counter is held at zero while no queue needs it, during system or master reset, and during stop. It is cleared for one cycle when a queue switches between the two timer modes, except when queue 2 switches while queue 1 is already active. Freeze interacts with conversions: it stops the counter at once if no conversion is running. If a conversion is running, the counter pauses and is cleared once that conversion ends. When freeze is released, counting starts again from zero.

Top module: `conv_trig_timer`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `mrst` is high, the count is zero, both triggers are low and both control registers are cleared, so both armed outputs read 0.
- R2: Mode encoding is 00 off, 01 externally triggered (no timer), 10 periodic timer and 11 interval single-scan timer. A queue is active when its mode is 10, or when its mode is 11 with the arm bit set. While neither queue is active, the count stays zero.
- R3: The count advances by one only on clock edges where `tick` is high. With interval select `s`, the count runs from 0 to 2^(7+s)-1. The tick at the top value returns it to zero, and that edge is the rollover.
- R4: While `stop` is high, the count is zero and both control registers are cleared. Writes are ignored during stop. After stop ends, the count stays zero until a timer mode is written.
- R5: In mode 11, the edge that issues a queue's trigger also clears that queue's arm bit, so the queue gets no further triggers until its arm bit is written to 1 again.
- R6: A write that changes a queue's mode from one timer mode (10 or 11) to the other clears the count at the edge where the write takes effect.
- R7: A queue-2 change between the timer modes does not clear the count while queue 1 is active.
- R8: While `freeze` is high and `conv_busy` is low, the count is zero from the next edge, and no trigger is issued.
- R9: While `freeze` and `conv_busy` are both high, the count holds its value and no trigger is issued. The count becomes zero at the first edge where `conv_busy` is low.
- R10: At the edge where `freeze` falls, the count is set to zero. It then advances on later ticks.
- R11: Each trigger output is high for exactly the one cycle after a rollover edge, and only for a queue that was active at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| mrst | input | 1 | Synchronous master reset, active high |
| stop | input | 1 | Low-power stop request |
| freeze | input | 1 | Debug freeze request |
| conv_busy | input | 1 | A conversion is in progress |
| tick | input | 1 | Prescaled-clock enable, one cycle wide |
| int_sel | input | SEL_W | Interval select s, interval = 2^(7+s) ticks |
| q1_wr | input | 1 | Write strobe for the queue-1 control register |
| q1_mode_d | input | 2 | Queue-1 mode to write |
| q1_sse_d | input | 1 | Queue-1 arm bit to write |
| q2_wr | input | 1 | Write strobe for the queue-2 control register |
| q2_mode_d | input | 2 | Queue-2 mode to write |
| q2_sse_d | input | 1 | Queue-2 arm bit to write |
| q1_trig | output | 1 | Queue-1 trigger pulse |
| q2_trig | output | 1 | Queue-2 trigger pulse |
| q1_armed | output | 1 | Queue-1 arm bit |
| q2_armed | output | 1 | Queue-2 arm bit |
| count | output | CNT_W | Current counter value |

## Verification
The embedded properties check these rules on every cycle: master reset, stop and idle freeze each clear the count; triggers are single-cycle and follow a tick while the queue is in a timer mode; and stop disarms both queues. Other behaviour depends on sequences of events and can only be shown by the bench's scenarios. This covers the exact interval length for different selects and tick spacings, and the self-disarm in single-scan mode. It also covers the clear on a mode switch and the queue-2 exception to it, the pause while a conversion runs under freeze, and the restart from zero when freeze ends.

// File: rtl/conv_trig_timer.sv
module conv_trig_timer #(
  parameter int SEL_W    = 4,
  parameter int BASE_EXP = 7,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrst,
  input  logic             stop,
  input  logic             freeze,
  input  logic             conv_busy,
  input  logic             tick,
  input  logic [SEL_W-1:0] int_sel,
  input  logic             q1_wr,
  input  logic [1:0]       q1_mode_d,
  input  logic             q1_sse_d,
  input  logic             q2_wr,
  input  logic [1:0]       q2_mode_d,
  input  logic             q2_sse_d,
  output logic             q1_trig,
  output logic             q2_trig,
  output logic             q1_armed,
  output logic             q2_armed,
  output logic [CNT_W-1:0] count
);

  localparam logic [1:0] M_PER = 2'b10;
  localparam logic [1:0] M_ISS = 2'b11;

  logic [1:0]       q1_mode_r, q2_mode_r;
  logic             q1_sse_r, q2_sse_r;
  logic [CNT_W-1:0] cnt_r;
  logic             frz_d;

  wire q1_act = (q1_mode_r == M_PER) | ((q1_mode_r == M_ISS) & q1_sse_r);
  wire q2_act = (q2_mode_r == M_PER) | ((q2_mode_r == M_ISS) & q2_sse_r);

  wire q1_chg = q1_wr & ~stop & ~mrst & q1_mode_r[1] & q1_mode_d[1] & (q1_mode_d != q1_mode_r);
  wire q2_chg = q2_wr & ~stop & ~mrst & q2_mode_r[1] & q2_mode_d[1] & (q2_mode_d != q2_mode_r) & ~q1_act;

  wire hold  = mrst | stop | ~(q1_act | q2_act) | (freeze & ~conv_busy);
  wire clr   = hold | q1_chg | q2_chg | (frz_d & ~freeze);

  wire [CNT_W-1:0] lim_m1 = (CNT_W'(1) << (BASE_EXP + int'(int_sel))) - CNT_W'(1);
  wire             at_end = (cnt_r == lim_m1);
  wire             roll   = ~clr & ~freeze & tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_r <= '0;
    else if (clr)                 cnt_r <= '0;
    else if (freeze)              cnt_r <= cnt_r;
    else if (tick)                cnt_r <= at_end ? '0 : cnt_r + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_d <= 1'b0;
    else        frz_d <= freeze;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           {q1_mode_r, q1_sse_r} <= '0;
    else if (mrst | stop)                 {q1_mode_r, q1_sse_r} <= '0;
    else if (q1_wr)                       {q1_mode_r, q1_sse_r} <= {q1_mode_d, q1_sse_d};
    else if (roll && q1_mode_r == M_ISS)  q1_sse_r <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           {q2_mode_r, q2_sse_r} <= '0;
    else if (mrst | stop)                 {q2_mode_r, q2_sse_r} <= '0;
    else if (q2_wr)                       {q2_mode_r, q2_sse_r} <= {q2_mode_d, q2_sse_d};
    else if (roll && q2_mode_r == M_ISS)  q2_sse_r <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1_trig <= 1'b0;
      q2_trig <= 1'b0;
    end else begin
      q1_trig <= roll & q1_act;
      q2_trig <= roll & q2_act;
    end
  end

  assign q1_armed = q1_sse_r;
  assign q2_armed = q2_sse_r;
  assign count    = cnt_r;

  // R1
  mrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (count == '0 && !q1_armed && !q2_armed));

  // R4
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (count == '0 && !q1_armed && !q2_armed && !q1_trig && !q2_trig));

  // R8
  frz_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !conv_busy) |=> (count == '0 && !q1_trig && !q2_trig));

  // R3
  trig_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_trig || q2_trig) |-> $past(tick));

  // R11
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_trig || q2_trig) |=> (!q1_trig && !q2_trig));

  // R11
  q1_trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q1_trig |-> $past(q1_mode_r[1]));

  // R11
  q2_trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q2_trig |-> $past(q2_mode_r[1]));

endmodule

// File: tb/test_conv_trig_timer.sv
module test_conv_trig_timer;
  localparam int CW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mrst = 0, stop = 0, freeze = 0, conv_busy = 0, tick = 0;
  logic [3:0] int_sel = 4'd0;
  logic q1_wr = 0, q1_sse_d = 0, q2_wr = 0, q2_sse_d = 0;
  logic [1:0] q1_mode_d = 0, q2_mode_d = 0;
  logic q1_trig, q2_trig, q1_armed, q2_armed;
  logic [CW-1:0] count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  conv_trig_timer i_conv_trig_timer (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .stop(stop), .freeze(freeze),
    .conv_busy(conv_busy), .tick(tick), .int_sel(int_sel),
    .q1_wr(q1_wr), .q1_mode_d(q1_mode_d), .q1_sse_d(q1_sse_d),
    .q2_wr(q2_wr), .q2_mode_d(q2_mode_d), .q2_sse_d(q2_sse_d),
    .q1_trig(q1_trig), .q2_trig(q2_trig), .q1_armed(q1_armed),
    .q2_armed(q2_armed), .count(count));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int q, input logic [1:0] m, input logic s);
    if (q == 1) begin q1_wr = 1; q1_mode_d = m; q1_sse_d = s; end
    else        begin q2_wr = 1; q2_mode_d = m; q2_sse_d = s; end
    @(negedge clk);
    q1_wr = 0; q2_wr = 0;
  endtask

  task automatic idle_all();
    freeze = 0; conv_busy = 0; stop = 0; tick = 1;
    wr(1, 2'b00, 0);
    wr(2, 2'b00, 0);
  endtask

  // counts negedges until q1 (q==1) or q2 trigger is seen; alt toggles tick
  task automatic wait_trig(input int q, input bit alt, input int lim, output int n);
    n = 0;
    do begin
      if (alt) tick = ~tick;
      @(negedge clk);
      n++;
    end while (!((q == 1) ? q1_trig : q2_trig) && n < lim);
    tick = 1;
  endtask

  task automatic t_reset();
    chk(count == 0, "R1 count after reset", count, 0);
    chk(!q1_trig && !q2_trig, "R1 triggers after reset", {q1_trig, q2_trig}, 0);
    chk(!q1_armed && !q2_armed, "R1 armed after reset", {q1_armed, q2_armed}, 0);
  endtask

  task automatic t_idle();
    int bad = 0;
    tick = 1;
    wr(1, 2'b01, 1); wr(2, 2'b00, 1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (count != 0 || q1_trig) bad++; end
    chk(bad == 0, "R2 no timer modes hold count", bad, 0);
    wr(1, 2'b11, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (count != 0 || q1_trig) bad++; end
    chk(bad == 0, "R2 unarmed single-scan holds count", bad, 0);
    idle_all();
  endtask

  task automatic t_period();
    int n;
    int_sel = 0; tick = 1;
    wr(2, 2'b01, 0);
    wr(1, 2'b10, 0);
    cyc(127);
    chk(count == 127 && !q1_trig, "R3 count before rollover", count, 127);
    @(negedge clk);
    chk(q1_trig && count == 0, "R11 trigger at rollover", {q1_trig, count}, 2);
    chk(!q2_trig, "R11 non-timer queue gets no trigger", q2_trig, 0);
    @(negedge clk);
    chk(!q1_trig && count == 1, "R11 trigger one cycle", {q1_trig, count}, 1);
    wait_trig(1, 0, 1000, n);
    chk(n == 127, "R3 period s=0", n, 127);
    wait_trig(1, 0, 1000, n);
    chk(n == 128, "R3 period s=0 steady", n, 128);
    wait_trig(1, 1, 2000, n);
    wait_trig(1, 1, 2000, n);
    chk(n == 256, "R3 period with tick every other cycle", n, 256);
    int_sel = 1;
    wait_trig(1, 0, 2000, n);
    wait_trig(1, 0, 2000, n);
    chk(n == 256, "R3 period s=1", n, 256);
    int_sel = 0;
    tick = 0;
    begin
      logic [CW-1:0] c0 = count;
      cyc(10);
      chk(count == c0 && !q1_trig, "R3 no advance without tick", count, c0);
    end
    tick = 1;
    idle_all();
  endtask

  task automatic t_interval();
    int n, bad = 0;
    int_sel = 0; tick = 1;
    wr(2, 2'b11, 1);
    chk(q2_armed, "R5 arm bit set by write", q2_armed, 1);
    wait_trig(2, 0, 1000, n);
    chk(n == 128 && q2_trig, "R5 single-scan first trigger", n, 128);
    chk(!q2_armed, "R5 arm bit cleared by trigger", q2_armed, 0);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (q2_trig || count != 0) bad++; end
    chk(bad == 0, "R5 no further triggers while disarmed", bad, 0);
    wr(2, 2'b11, 1);
    wait_trig(2, 0, 1000, n);
    chk(n == 128, "R5 re-armed queue triggers again", n, 128);
    idle_all();
  endtask

  task automatic t_modechg();
    tick = 1; int_sel = 0;
    wr(1, 2'b10, 0);
    cyc(50);
    chk(count == 50, "R6 count before change", count, 50);
    wr(1, 2'b11, 1);
    chk(count == 0, "R6 queue-1 timer mode change clears", count, 0);
    @(negedge clk);
    chk(count == 1, "R6 counting resumes", count, 1);
    idle_all();
    wr(2, 2'b10, 0);
    cyc(30);
    wr(2, 2'b11, 1);
    chk(count == 0, "R6 queue-2 change clears with queue 1 idle", count, 0);
    idle_all();
    wr(1, 2'b10, 0);
    wr(2, 2'b10, 0);
    cyc(40);
    begin
      logic [CW-1:0] c0 = count;
      wr(2, 2'b11, 1);
      chk(count == c0 + 1, "R7 queue-2 change ignored with queue 1 active", count, c0 + 1);
    end
    idle_all();
  endtask

  task automatic t_freeze();
    int bad = 0;
    tick = 1; int_sel = 0;
    wr(1, 2'b10, 0);
    cyc(40);
    freeze = 1; conv_busy = 0;
    @(negedge clk);
    chk(count == 0, "R8 idle freeze clears at once", count, 0);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (count != 0 || q1_trig) bad++; end
    chk(bad == 0, "R8 count held during freeze", bad, 0);
    freeze = 0;
    @(negedge clk);
    chk(count == 0, "R10 restart value after freeze", count, 0);
    @(negedge clk);
    chk(count == 1, "R10 counting from zero", count, 1);
    cyc(30);
    begin
      logic [CW-1:0] c0 = count;
      freeze = 1; conv_busy = 1;
      cyc(5);
      chk(count == c0 && !q1_trig, "R9 count paused during busy freeze", count, c0);
    end
    conv_busy = 0;
    @(negedge clk);
    chk(count == 0, "R9 cleared after conversion ends", count, 0);
    freeze = 0;
    cyc(2);
    chk(count == 1, "R10 resumes after freeze", count, 1);
    cyc(20);
    freeze = 1; conv_busy = 1;
    cyc(3);
    freeze = 0;
    @(negedge clk);
    chk(count == 0, "R10 freeze fall clears while busy", count, 0);
    conv_busy = 0;
    idle_all();
  endtask

  task automatic t_stop();
    int bad = 0;
    tick = 1;
    wr(1, 2'b11, 1);
    wr(2, 2'b10, 0);
    cyc(20);
    stop = 1;
    @(negedge clk);
    chk(count == 0 && !q1_armed, "R4 stop clears count and registers", {count, q1_armed}, 0);
    wr(1, 2'b11, 1);
    chk(!q1_armed, "R4 write ignored during stop", q1_armed, 0);
    stop = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (count != 0 || q1_trig || q2_trig) bad++; end
    chk(bad == 0, "R4 held after stop until mode written", bad, 0);
    wr(1, 2'b10, 0);
    cyc(5);
    chk(count == 5, "R4 counts after valid mode written", count, 5);
    mrst = 1;
    @(negedge clk);
    mrst = 0;
    chk(count == 0 && !q1_armed, "R1 master reset clears", count, 0);
    cyc(5);
    chk(count == 0, "R1 registers cleared by master reset", count, 0);
    idle_all();
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_period();
    t_interval();
    t_modechg();
    t_freeze();
    t_stop();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule